// File: doc/BRIEF.md
# Draw Predication Control Unit

This block holds the draw-predication state of a command processor and gives every draw request an execute-or-skip verdict. Decoded command packets come in as an opcode with three payload dwords. Three opcodes are acted on: a global enable, a local enable and a predicate-set command. Every other opcode is accepted and dropped.

A predicate-set command whose source field selects memory starts one 64-bit read through a request/response port. The block tests the returned value against zero, using the polarity given in the packet, and latches the outcome as the predicate. While that read is in flight, both draws and further packets are held off.

A draw is skipped only when the global enable, the local enable and a latched predicate are all present and the predicate fails. A skipped draw is still accepted on the handshake and carries a skip flag, so the command stream keeps moving. The global enable is meant for the application's own predication. The local enable lets internal draws run without disturbing that state.

Top module: `draw_pred_ctrl`

## Requirements
- R1: After reset the global enable, the local enable and the predicate-valid flag are clear and the predicate reads as passing. `draw_skip_o`, `mem_req_o` and `err_o` are low, and both ready outputs are high.
- R2: A packet with opcode 0x19 writes payload dword 0 bit 0 into the global enable. When that bit is 1, the predicate is also reset to passing and the local enable is set to 1. When it is 0, only the global enable changes.
- R3: A packet with opcode 0x1a writes payload dword 0 bit 0 into the local enable and changes no other state.
- R4: `draw_skip_o` is high only when `draw_valid_i` is high and the global enable, the local enable and the predicate-valid flag are all set while the latched predicate fails. Otherwise it is low.
- R5: A packet with opcode 0x4e whose dword 0 bits 7:4 equal 5 raises `mem_req_o` on the next cycle. The address is {dword 2, dword 1}. Both the request and the address are held until a cycle in which `mem_rsp_valid_i` is high.
- R6: Dword 0 bit 8 of the 0x4e packet selects the test. With 0, the predicate passes if the 64-bit response is nonzero. With 1, it passes if the response is zero. All 64 bits take part in the test.
- R7: From the cycle in which `mem_req_o` rises through the response cycle, `draw_ready_o` and `pkt_ready_o` are low. The predicate that was read is latched at the response edge, and the predicate-valid flag is set there.
- R8: A 0x4e packet with a source field other than 5 issues no read and leaves all predicate state unchanged. It raises `err_o` for exactly the cycle after the packet is accepted.
- R9: Packets with any other opcode are accepted and have no effect on the predication state or on any output.
- R10: A draw is accepted whenever `draw_valid_i` and `draw_ready_o` are both high, and `draw_skip_o` gives that draw's verdict in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet present |
| pkt_ready_o | output | 1 | Packet accepted when high together with valid |
| pkt_opcode_i | input | 8 | Packet opcode |
| pkt_dw0_i | input | DW | Payload dword 0 (flags, source, test) |
| pkt_dw1_i | input | DW | Payload dword 1 (address low half) |
| pkt_dw2_i | input | DW | Payload dword 2 (address high half) |
| mem_req_o | output | 1 | Predicate read request, held until response |
| mem_addr_o | output | 2*DW | Predicate read address |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | 2*DW | Read data |
| draw_valid_i | input | 1 | Draw request present |
| draw_ready_o | output | 1 | Draw accepted when high together with valid |
| draw_skip_o | output | 1 | Verdict for the accepted draw: 1 skip, 0 execute |
| err_o | output | 1 | One-cycle pulse for an unsupported predicate source |

## Verification
Some properties are checked on every cycle against the internal enables and predicate:

- a skip appears only when all three gating conditions hold and the predicate fails;
- both ready outputs are low while a read is outstanding;
- the read request and address are stable until the response arrives;
- a global enable restores the passing predicate and the local bit;
- local, unsupported-source and unrelated packets leave the state they must not touch alone;
- each error pulse traces back to a bad-source packet.

Other behaviour shows up only in the bench's scenarios:

- the zero-test polarity over the full 64-bit width, including a value whose only set bit is the top one;
- a local disable followed by a re-enable that brings back the earlier predicate;
- a global re-enable that clears a failing predicate;
- the verdicts that draws actually receive.

// File: rtl/draw_pred_pkg.sv
package draw_pred_pkg;
  localparam int OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_GLB_EN = 8'h19;
  localparam logic [OPC_W-1:0] OPC_LOC_EN = 8'h1a;
  localparam logic [OPC_W-1:0] OPC_PRED_SET = 8'h4e;

  localparam int EN_BIT   = 0;
  localparam int SRC_LO   = 4;
  localparam int SRC_HI   = 7;
  localparam int TEST_BIT = 8;
  localparam int SRC_W    = SRC_HI - SRC_LO + 1;
  localparam logic [SRC_W-1:0] SRC_MEM = 4'd5;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_GLB,
    CMD_LOC,
    CMD_SET
  } cmd_e;

  typedef struct packed {
    cmd_e cmd;
    logic en;
    logic src_ok;
    logic test_zero;
  } cmd_t;
endpackage

// File: rtl/pred_decode.sv
module pred_decode
  import draw_pred_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [DW-1:0]    dw0_i,
  output cmd_t             cmd_o
);
  logic [SRC_W-1:0] src;
  logic             unused_dw0;

  assign src        = dw0_i[SRC_HI:SRC_LO];
  assign unused_dw0 = ^{dw0_i[DW-1:TEST_BIT+1], dw0_i[SRC_LO-1:EN_BIT+1]};

  always_comb begin
    cmd_o.en        = dw0_i[EN_BIT];
    cmd_o.src_ok    = (src == SRC_MEM);
    cmd_o.test_zero = dw0_i[TEST_BIT];
    unique case (opcode_i)
      OPC_GLB_EN:   cmd_o.cmd = CMD_GLB;
      OPC_LOC_EN:   cmd_o.cmd = CMD_LOC;
      OPC_PRED_SET: cmd_o.cmd = CMD_SET;
      default:      cmd_o.cmd = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/pred_fetch.sv
module pred_fetch #(
  parameter int DW = 32,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] addr_lo_i,
  input  logic [DW-1:0] addr_hi_i,
  input  logic          test_zero_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          pass_o
);
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic          test_q;
  logic          is_zero;

  assign is_zero    = (mem_rsp_data_i == '0);
  assign busy_o     = busy_q;
  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q;
  assign load_o     = busy_q & mem_rsp_valid_i;
  // test_q=1: pass on zero; test_q=0: pass on nonzero
  assign pass_o     = test_q ? is_zero : ~is_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      test_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      addr_q <= {addr_hi_i, addr_lo_i};
      test_q <= test_zero_i;
    end else if (load_o) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pred_state.sv
module pred_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic glb_wr_i,
  input  logic loc_wr_i,
  input  logic en_i,
  input  logic load_i,
  input  logic pass_i,
  output logic glb_o,
  output logic loc_o,
  output logic valid_o,
  output logic pass_o
);
  logic glb_q, loc_q, valid_q, pass_q;

  assign glb_o   = glb_q;
  assign loc_o   = loc_q;
  assign valid_o = valid_q;
  assign pass_o  = pass_q;

  // writes and loads never coincide: packets stall while a load is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q   <= 1'b0;
      loc_q   <= 1'b0;
      valid_q <= 1'b0;
      pass_q  <= 1'b1;
    end else if (glb_wr_i) begin
      glb_q <= en_i;
      if (en_i) begin
        pass_q <= 1'b1;
        loc_q  <= 1'b1;
      end
    end else if (loc_wr_i) begin
      loc_q <= en_i;
    end else if (load_i) begin
      valid_q <= 1'b1;
      pass_q  <= pass_i;
    end
  end
endmodule

// File: rtl/draw_gate.sv
module draw_gate (
  input  logic draw_valid_i,
  input  logic busy_i,
  input  logic glb_i,
  input  logic loc_i,
  input  logic valid_i,
  input  logic pass_i,
  output logic draw_ready_o,
  output logic draw_skip_o
);
  logic active;

  assign active       = glb_i & loc_i & valid_i;
  assign draw_ready_o = ~busy_i;
  assign draw_skip_o  = draw_valid_i & active & ~pass_i;
endmodule

// File: rtl/draw_pred_ctrl.sv
module draw_pred_ctrl
  import draw_pred_pkg::*;
#(
  parameter int DW = 32,
  localparam int AW = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  output logic             pkt_ready_o,
  input  logic [OPC_W-1:0] pkt_opcode_i,
  input  logic [DW-1:0]    pkt_dw0_i,
  input  logic [DW-1:0]    pkt_dw1_i,
  input  logic [DW-1:0]    pkt_dw2_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [AW-1:0]    mem_rsp_data_i,
  input  logic             draw_valid_i,
  output logic             draw_ready_o,
  output logic             draw_skip_o,
  output logic             err_o
);
  cmd_t cmd;
  logic accept, glb_wr, loc_wr, start, bad_src;
  logic busy, load, load_pass;
  logic glb_en, loc_en, pred_valid, pred_pass;
  logic err_q;

  pred_decode #(.DW(DW)) u_decode (
    .opcode_i (pkt_opcode_i),
    .dw0_i    (pkt_dw0_i),
    .cmd_o    (cmd)
  );

  assign pkt_ready_o = ~busy;
  assign accept      = pkt_valid_i & ~busy;
  assign glb_wr      = accept & (cmd.cmd == CMD_GLB);
  assign loc_wr      = accept & (cmd.cmd == CMD_LOC);
  assign start       = accept & (cmd.cmd == CMD_SET) & cmd.src_ok;
  assign bad_src     = accept & (cmd.cmd == CMD_SET) & ~cmd.src_ok;

  pred_fetch #(.DW(DW)) u_fetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start),
    .addr_lo_i       (pkt_dw1_i),
    .addr_hi_i       (pkt_dw2_i),
    .test_zero_i     (cmd.test_zero),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .busy_o          (busy),
    .load_o          (load),
    .pass_o          (load_pass)
  );

  pred_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .glb_wr_i (glb_wr),
    .loc_wr_i (loc_wr),
    .en_i     (cmd.en),
    .load_i   (load),
    .pass_i   (load_pass),
    .glb_o    (glb_en),
    .loc_o    (loc_en),
    .valid_o  (pred_valid),
    .pass_o   (pred_pass)
  );

  draw_gate u_gate (
    .draw_valid_i (draw_valid_i),
    .busy_i       (busy),
    .glb_i        (glb_en),
    .loc_i        (loc_en),
    .valid_i      (pred_valid),
    .pass_i       (pred_pass),
    .draw_ready_o (draw_ready_o),
    .draw_skip_o  (draw_skip_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= bad_src;
  end

  assign err_o = err_q;
endmodule

// File: rtl/draw_pred_chk.sv
module draw_pred_chk
  import draw_pred_pkg::*;
#(
  parameter int DW = 32,
  localparam int AW = 2 * DW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_valid_i,
  input logic             pkt_ready_o,
  input logic [OPC_W-1:0] pkt_opcode_i,
  input logic [DW-1:0]    pkt_dw0_i,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rsp_valid_i,
  input logic             draw_ready_o,
  input logic             draw_skip_o,
  input logic             err_o,
  input logic             glb_en,
  input logic             loc_en,
  input logic             pred_valid,
  input logic             pred_pass
);
  logic acc, is_set, src_bad, is_other;

  assign acc      = pkt_valid_i & pkt_ready_o;
  assign is_set   = (pkt_opcode_i == OPC_PRED_SET);
  assign src_bad  = (pkt_dw0_i[SRC_HI:SRC_LO] != SRC_MEM);
  assign is_other = (pkt_opcode_i != OPC_GLB_EN) && (pkt_opcode_i != OPC_LOC_EN) && !is_set;

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!draw_ready_o && !pkt_ready_o));

  assert_skip_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draw_skip_o |-> (glb_en && loc_en && pred_valid && !pred_pass));

  assert_glb_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pkt_opcode_i == OPC_GLB_EN && pkt_dw0_i[EN_BIT]) |=> (glb_en && loc_en && pred_pass));

  assert_loc_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pkt_opcode_i == OPC_LOC_EN) |=>
      ($stable(glb_en) && $stable(pred_pass) && $stable(pred_valid) && loc_en == $past(pkt_dw0_i[EN_BIT])));

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_err_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(acc && is_set && src_bad));

  assert_bad_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_set && src_bad) |=> (!mem_req_o && $stable(pred_valid) && $stable(pred_pass)));

  assert_other_opc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_other) |=>
      ($stable(glb_en) && $stable(loc_en) && $stable(pred_valid) && $stable(pred_pass) && !mem_req_o));
endmodule

bind draw_pred_ctrl draw_pred_chk #(.DW(DW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pkt_valid_i     (pkt_valid_i),
  .pkt_ready_o     (pkt_ready_o),
  .pkt_opcode_i    (pkt_opcode_i),
  .pkt_dw0_i       (pkt_dw0_i),
  .mem_req_o       (mem_req_o),
  .mem_addr_o      (mem_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .draw_ready_o    (draw_ready_o),
  .draw_skip_o     (draw_skip_o),
  .err_o           (err_o),
  .glb_en          (glb_en),
  .loc_en          (loc_en),
  .pred_valid      (pred_valid),
  .pred_pass       (pred_pass)
);

// File: tb/draw_pred_ctrl_tb.sv
`timescale 1ns/1ps
module draw_pred_ctrl_tb;
  localparam int DW = 32;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic [7:0] pkt_op = '0;
  logic [DW-1:0] dw0 = '0, dw1 = '0, dw2 = '0;
  logic mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;
  logic draw_valid = 1'b0;
  logic pkt_ready, mem_req, draw_ready, draw_skip, err;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  draw_pred_ctrl #(.DW(DW)) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .pkt_valid_i     (pkt_valid),
    .pkt_ready_o     (pkt_ready),
    .pkt_opcode_i    (pkt_op),
    .pkt_dw0_i       (dw0),
    .pkt_dw1_i       (dw1),
    .pkt_dw2_i       (dw2),
    .mem_req_o       (mem_req),
    .mem_addr_o      (mem_addr),
    .mem_rsp_valid_i (mem_rsp_valid),
    .mem_rsp_data_i  (mem_rsp_data),
    .draw_valid_i    (draw_valid),
    .draw_ready_o    (draw_ready),
    .draw_skip_o     (draw_skip),
    .err_o           (err)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_glb, m_loc, m_valid, m_pass, m_busy, m_err, m_test;
  logic [AW-1:0] m_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_glb = 0; m_loc = 0; m_valid = 0; m_pass = 1;
      m_busy = 0; m_err = 0; m_test = 0; m_addr = '0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_err = 0;
      if (was_busy && mem_rsp_valid) begin
        m_valid = 1;
        m_pass = m_test ? (mem_rsp_data == 0) : (mem_rsp_data != 0);
        m_busy = 0;
      end
      if (pkt_valid && !was_busy) begin
        if (pkt_op == 8'h19) begin
          m_glb = dw0[0];
          if (dw0[0]) begin m_pass = 1; m_loc = 1; end
        end else if (pkt_op == 8'h1a) begin
          m_loc = dw0[0];
        end else if (pkt_op == 8'h4e) begin
          if (dw0[7:4] == 4'd5) begin
            m_busy = 1; m_addr = {dw2, dw1}; m_test = dw0[8];
          end else m_err = 1;
        end
      end
    end
  end

  // per-cycle comparison, mid low phase
  always begin
    @(negedge clk);
    #5;
    if (rst_n && !done) begin
      chk("R4 skip", {63'd0, draw_skip}, {63'd0, draw_valid & m_glb & m_loc & m_valid & ~m_pass});
      chk("R7 draw_ready", {63'd0, draw_ready}, {63'd0, ~m_busy});
      chk("R7 pkt_ready", {63'd0, pkt_ready}, {63'd0, ~m_busy});
      chk("R5 req", {63'd0, mem_req}, {63'd0, m_busy});
      if (m_busy) chk("R5 addr", mem_addr, m_addr);
      chk("R8 err", {63'd0, err}, {63'd0, m_err});
    end
  end

  // memory responder
  int mem_lat = 2;
  int lat_cnt = 0;
  always @(negedge clk) begin
    if (mem_req && !mem_rsp_valid) begin
      if (lat_cnt >= mem_lat) begin mem_rsp_valid = 1; lat_cnt = 0; end
      else lat_cnt++;
    end else mem_rsp_valid = 0;
  end

  task automatic send(input logic [7:0] op, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [DW-1:0] d2);
    @(negedge clk);
    pkt_valid = 1; pkt_op = op; dw0 = d0; dw1 = d1; dw2 = d2;
    @(negedge clk);
    pkt_valid = 0; pkt_op = '0; dw0 = '0;
    #5;
  endtask

  task automatic set_mem(input bit test_zero, input logic [AW-1:0] data);
    mem_rsp_data = data;
    send(8'h4e, {23'd0, test_zero, 4'd5, 4'd0}, 32'h1000_0040, 32'h0000_00ab);
    chk("R7 stall draw", {63'd0, draw_ready}, 64'd0);
    chk("R5 addr", mem_addr, 64'h0000_00ab_1000_0040);
    while (mem_req) begin @(negedge clk); #5; end
  endtask

  task automatic draw(input bit exp_skip, input string tag);
    @(negedge clk);
    draw_valid = 1;
    #5;
    chk({tag, " R10 ready"}, {63'd0, draw_ready}, 64'd1);
    chk(tag, {63'd0, draw_skip}, {63'd0, exp_skip});
    @(negedge clk);
    draw_valid = 0;
    #5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    chk("R1 skip", {63'd0, draw_skip}, 64'd0);
    chk("R1 draw_ready", {63'd0, draw_ready}, 64'd1);
    chk("R1 pkt_ready", {63'd0, pkt_ready}, 64'd1);
    chk("R1 req", {63'd0, mem_req}, 64'd0);
    chk("R1 err", {63'd0, err}, 64'd0);
    draw(0, "R1 idle verdict");

    set_mem(0, 64'd0);                     // fails, but predication off
    draw(0, "R4 global off");
    send(8'h19, 32'h1, 0, 0);              // global on resets predicate
    draw(0, "R2 pred reset");
    set_mem(0, 64'd0);
    draw(1, "R6 ne0 on zero skips");

    send(8'h1a, 32'h0, 0, 0);
    draw(0, "R3 local off");
    send(8'h1a, 32'h1, 0, 0);
    draw(1, "R3 predicate kept");

    set_mem(1, 64'd0);
    draw(0, "R6 eq0 on zero passes");
    set_mem(1, 64'h8000_0000_0000_0000);
    draw(1, "R6 eq0 top bit fails");
    set_mem(0, 64'h8000_0000_0000_0000);
    draw(0, "R6 ne0 top bit passes");
    set_mem(0, 64'd0);

    send(8'h4e, {23'd0, 1'b1, 4'd3, 4'd0}, 0, 0);
    chk("R8 err pulse", {63'd0, err}, 64'd1);
    chk("R8 no read", {63'd0, mem_req}, 64'd0);
    @(negedge clk); #5;
    chk("R8 err one cycle", {63'd0, err}, 64'd0);
    draw(1, "R8 state kept");

    send(8'h20, 32'h1, 0, 0);
    draw(1, "R9 other opcode");
    send(8'h19, 32'h2, 0, 0);
    draw(0, "R2 global off");
    send(8'h1a, 32'h0, 0, 0);
    send(8'h19, 32'h1, 0, 0);
    draw(0, "R2 global on passes");
    set_mem(0, 64'd0);
    draw(1, "R2 local forced on");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule